// File: doc/BRIEF.md
# Synthesizer Serial Control Register Bank

This block is the programming front end of a frequency synthesizer. A host writes 24-bit control words over a three-wire serial link made of a serial clock, a data line and a load strobe. The two lowest bits of each word choose where it goes: the reference divider register, the dual-modulus divider register, the function register, or the initialization register. Loads to the last two write the same function storage. The block keeps every register, fires a one-cycle internal reset toward the divider counters, and drives the charge-pump high-impedance control, the counter hold and both power-down outputs.

The three serial pins are asynchronous to the system clock. They pass through synchronizers and are edge-detected in the system clock domain, so a serial phase must last several system-clock cycles. The link has no flow control and no back-pressure. The host paces every bit and every load strobe, and the block accepts each rising edge it sees. An initialization load arms the block so that the next dual-modulus load fires the counter reset once more. The chip-enable pin forces power-down at once and leaves the stored registers as they are.

Top module: `synth_ctrl_bank`

## Requirements
- R1: On each rising edge of ser_clk the bit on ser_data is shifted in, most significant bit first. On a rising edge of ser_le the last 24 bits shifted form the word. Bits [1:0] of the word are the address and bits [23:2] are the payload.
- R2: Address 0 writes the payload to ref_reg, address 1 to mod_reg and address 2 to func_reg. The two registers that are not addressed keep their values.
- R3: Address 3 writes the payload to func_reg exactly as address 2 does, leaves ref_reg and mod_reg unchanged, and fires rst_pulse.
- R4: Each rst_pulse lasts exactly one system-clock cycle. It rises on the same clock edge on which the register is written.
- R5: The first address-1 load after an address-3 load fires rst_pulse. Later address-1 loads do not fire it until another address-3 load occurs. Address-0 and address-2 loads never fire it.
- R6: While rst_pulse is high, cnt_hold and cp_hiz are both high.
- R7: func_reg bit 0 (word bit 2) is the counter-reset control. While it is 1, cnt_hold and cp_hiz are high and pd_sync is not set by it.
- R8: func_reg bit 2 (word bit 4) is the pump-disable control. While it is 1, cp_hiz is high. It has no effect on cnt_hold.
- R9: The request for synchronous power-down is chip_en=1 with func_reg bit 1 (word bit 3) at 1 and func_reg bit 3 (word bit 5) at 0. pd_sync goes high one cycle after a rst_pulse that occurs while this request holds. It stays high while the request holds and clears one cycle after the request drops.
- R10: pd_async equals the inverse of chip_en with no clock involved. Register contents are kept while chip_en is low, and loads still take effect during that time.
- R11: After reset all three registers are zero, the block is not armed, and rst_pulse, cnt_hold, cp_hiz and pd_sync are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; a rising edge transfers the word |
| chip_en | input | 1 | Chip enable; low forces power-down |
| ref_reg | output | 22 | Reference divider register payload |
| mod_reg | output | 22 | Dual-modulus divider register payload |
| func_reg | output | 22 | Function register payload |
| rst_pulse | output | 1 | One-cycle internal counter reset |
| cnt_hold | output | 1 | Hold counters at their load point |
| cp_hiz | output | 1 | Charge pump high impedance |
| pd_sync | output | 1 | Synchronous power-down |
| pd_async | output | 1 | Asynchronous power-down |

## Verification
The assertions assume that two load strobes are separated by more than one system-clock cycle after synchronization. This follows from the input pacing, which holds every serial level for several clock cycles. They also assume that chip_en is a clean level in the clock domain. The stimulus holds ser_clk, ser_data and ser_le at each level for three system-clock cycles. It changes ser_data only while ser_clk is low and changes chip_en only between words. Random words and addresses are mixed with directed sequences for arming, counter reset and chip enable.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 2;
  localparam int PAY_W  = WORD_W - ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    DST_REF  = 2'd0,
    DST_MOD  = 2'd1,
    DST_FUNC = 2'd2,
    DST_INIT = 2'd3
  } dest_e;

  // bit positions inside the function payload
  localparam int FB_CNT_RST = 0;
  localparam int FB_PD_A    = 1;
  localparam int FB_PUMP_Z  = 2;
  localparam int FB_PD_B    = 3;
endpackage

// File: rtl/ctrl_sync_cell.sv
module ctrl_sync_cell #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d;
  end

  genvar g;
  generate
    for (g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  assign q    = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ctrl_serial_rx.sv
module ctrl_serial_rx #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  logic sclk_q, sclk_rise;
  logic data_q, data_rise;
  logic le_q, le_rise;
  logic [WORD_W-1:0] shreg;

  ctrl_sync_cell #(.STAGES(SYNC_STAGES)) u_sclk (
    .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_q), .rise(sclk_rise));
  ctrl_sync_cell #(.STAGES(SYNC_STAGES)) u_data (
    .clk(clk), .rst_n(rst_n), .d(ser_data), .q(data_q), .rise(data_rise));
  ctrl_sync_cell #(.STAGES(SYNC_STAGES)) u_le (
    .clk(clk), .rst_n(rst_n), .d(ser_le), .q(le_q), .rise(le_rise));

  logic unused_lv;
  assign unused_lv = sclk_q ^ data_rise ^ le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[WORD_W-2:0], data_q};
  end

  assign word_o = shreg;
  assign load_o = le_rise;
endmodule

// File: rtl/ctrl_latch_file.sv
module ctrl_latch_file
  import synth_ctrl_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 2,
  localparam int PW    = WORD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PW-1:0]     ref_o,
  output logic [PW-1:0]     mod_o,
  output logic [PW-1:0]     func_o,
  output logic              init_ld_o,
  output logic              mod_ld_o
);
  localparam int NREG = 3;

  dest_e          dst;
  logic [PW-1:0]  pay;
  logic [PW-1:0]  store [NREG];
  logic [NREG-1:0] wen;

  assign dst = dest_e'(word_i[ADDR_W-1:0]);
  assign pay = word_i[WORD_W-1:ADDR_W];

  always_comb begin
    wen = '0;
    if (load_i) begin
      unique case (dst)
        DST_REF:  wen[0] = 1'b1;
        DST_MOD:  wen[1] = 1'b1;
        DST_FUNC,
        DST_INIT: wen[2] = 1'b1;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      store[g] <= '0;
        else if (wen[g]) store[g] <= pay;
      end
    end
  endgenerate

  assign ref_o     = store[0];
  assign mod_o     = store[1];
  assign func_o    = store[2];
  assign init_ld_o = load_i && (dst == DST_INIT);
  assign mod_ld_o  = load_i && (dst == DST_MOD);
endmodule

// File: rtl/ctrl_reset_seq.sv
module ctrl_reset_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic init_ld,
  input  logic mod_ld,
  input  logic chip_en,
  input  logic pd_a,
  input  logic pd_b,
  output logic rst_pulse,
  output logic pd_sync
);
  logic armed;
  logic pd_req;

  assign pd_req = chip_en & pd_a & ~pd_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      rst_pulse <= 1'b0;
      pd_sync   <= 1'b0;
    end else begin
      rst_pulse <= init_ld | (mod_ld & armed);
      if (init_ld)     armed <= 1'b1;
      else if (mod_ld) armed <= 1'b0;
      pd_sync <= pd_req & (pd_sync | rst_pulse);
    end
  end
endmodule

// File: rtl/synth_ctrl_bank.sv
module synth_ctrl_bank
  import synth_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  input  logic             chip_en,
  output logic [PAY_W-1:0] ref_reg,
  output logic [PAY_W-1:0] mod_reg,
  output logic [PAY_W-1:0] func_reg,
  output logic             rst_pulse,
  output logic             cnt_hold,
  output logic             cp_hiz,
  output logic             pd_sync,
  output logic             pd_async
);
  logic [WORD_W-1:0] word;
  logic load, init_ld, mod_ld;

  ctrl_serial_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .word_o(word), .load_o(load));

  ctrl_latch_file #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_i(load), .word_i(word),
    .ref_o(ref_reg), .mod_o(mod_reg), .func_o(func_reg),
    .init_ld_o(init_ld), .mod_ld_o(mod_ld));

  ctrl_reset_seq u_seq (
    .clk(clk), .rst_n(rst_n), .init_ld(init_ld), .mod_ld(mod_ld),
    .chip_en(chip_en), .pd_a(func_reg[FB_PD_A]), .pd_b(func_reg[FB_PD_B]),
    .rst_pulse(rst_pulse), .pd_sync(pd_sync));

  assign cnt_hold = rst_pulse | func_reg[FB_CNT_RST];
  assign cp_hiz   = cnt_hold | func_reg[FB_PUMP_Z];
  assign pd_async = ~chip_en;
endmodule

// File: rtl/synth_ctrl_bank_chk.sv
module synth_ctrl_bank_chk
  import synth_ctrl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             chip_en,
  input logic [PAY_W-1:0] func_reg,
  input logic             rst_pulse,
  input logic             cnt_hold,
  input logic             cp_hiz,
  input logic             pd_sync,
  input logic             pd_async
);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  assert_pulse_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (cnt_hold && cp_hiz));

  assert_cntrst_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    func_reg[FB_CNT_RST] |-> (cnt_hold && cp_hiz));

  assert_pump_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    func_reg[FB_PUMP_Z] |-> cp_hiz);

  assert_pdsync_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_sync) |-> $past(rst_pulse));

  assert_pdsync_needs_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_sync |-> $past(chip_en));

  assert_ce_async_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> pd_async);
endmodule

bind synth_ctrl_bank synth_ctrl_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .func_reg(func_reg),
  .rst_pulse(rst_pulse), .cnt_hold(cnt_hold), .cp_hiz(cp_hiz),
  .pd_sync(pd_sync), .pd_async(pd_async));

// File: tb/synth_ctrl_bank_tb_top.sv
module synth_ctrl_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
  logic [21:0] ref_reg, mod_reg, func_reg;
  logic rst_pulse, cnt_hold, cp_hiz, pd_sync, pd_async;

  always #5 clk = ~clk;

  synth_ctrl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .chip_en(chip_en), .ref_reg(ref_reg), .mod_reg(mod_reg),
    .func_reg(func_reg), .rst_pulse(rst_pulse), .cnt_hold(cnt_hold),
    .cp_hiz(cp_hiz), .pd_sync(pd_sync), .pd_async(pd_async));

  int n_chk = 0, n_bad = 0;
  int pulse_cnt = 0, run_len = 0, run_max = 0;
  bit done = 0;

  logic [21:0] m_ref = '0, m_mod = '0, m_func = '0;
  bit m_armed = 0, m_pd = 0;

  always @(negedge clk) begin
    if (rst_pulse === 1'b1) begin
      pulse_cnt++; run_len++;
      if (run_len > run_max) run_max = run_len;
    end else run_len = 0;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(logic [21:0] pay, logic [1:0] addr);
    logic [23:0] w;
    w = {pay, addr};
    for (int i = 23; i >= 0; i--) begin
      ser_data = w[i];
      wait_clk(3);
      ser_clk = 1'b1;
      wait_clk(3);
      ser_clk = 1'b0;
    end
    ser_le = 1'b1;
    wait_clk(3);
    ser_le = 1'b0;
    wait_clk(6);
  endtask

  function automatic bit pulse_exp(logic [1:0] a, bit armed);
    return (a == 2'd3) || (a == 2'd1 && armed);
  endfunction

  function automatic bit pd_req(logic [21:0] f, bit ce);
    return ce && f[1] && !f[3];
  endfunction

  task automatic load_and_check(logic [21:0] pay, logic [1:0] addr);
    int p0;
    bit pe;
    p0 = pulse_cnt;
    pe = pulse_exp(addr, m_armed);
    send(pay, addr);
    case (addr)
      2'd0: m_ref = pay;
      2'd1: m_mod = pay;
      default: m_func = pay;
    endcase
    if (addr == 2'd3) m_armed = 1;
    else if (addr == 2'd1) m_armed = 0;
    m_pd = pd_req(m_func, chip_en) && (m_pd || pe);
    chk("R2 ref_reg", ref_reg, m_ref);
    chk("R2 mod_reg", mod_reg, m_mod);
    chk("R3 func_reg", func_reg, m_func);
    chk("R5 pulse count", pulse_cnt - p0, pe);
    chk("R7 cnt_hold", cnt_hold, m_func[0]);
    chk("R8 cp_hiz", cp_hiz, m_func[0] | m_func[2]);
    chk("R9 pd_sync", pd_sync, m_pd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R11 reset state
    chk("R11 ref_reg", ref_reg, 0);
    chk("R11 mod_reg", mod_reg, 0);
    chk("R11 func_reg", func_reg, 0);
    chk("R11 outputs", {rst_pulse, cnt_hold, cp_hiz, pd_sync}, 0);

    // R1 MSB-first: distinct pattern in reference register
    load_and_check(22'h2A5C3B, 2'd0);
    chk("R1 bit order", ref_reg, 22'h2A5C3B);
    // R5 AB load without arming: no pulse
    load_and_check(22'h000123, 2'd1);
    // R3 init with sync power-down request (word bit3=1, bit5=0), R9
    load_and_check(22'h000002, 2'd3);
    chk("R9 pd_sync after init", pd_sync, 1);
    // R5 first AB after init pulses, second does not
    load_and_check(22'h001111, 2'd1);
    load_and_check(22'h002222, 2'd1);
    // R10 chip_en low: immediate async, pd_sync drops, contents kept
    chip_en = 1'b0;
    #1;
    chk("R10 pd_async immediate", pd_async, 1);
    wait_clk(2);
    m_pd = 0;
    chk("R9 pd_sync cleared by CE", pd_sync, 0);
    chk("R10 mod_reg kept", mod_reg, 22'h002222);
    load_and_check(22'h00ABCD, 2'd0);
    chip_en = 1'b1;
    #1;
    chk("R10 pd_async released", pd_async, 0);
    wait_clk(2);
    chk("R10 ref after CE", ref_reg, 22'h00ABCD);
    chk("R9 no pd_sync without pulse", pd_sync, 0);
    // R7 counter reset with pd request: holds, no pd_sync
    load_and_check(22'h000003, 2'd2);
    chk("R7 no pd_sync from F1", pd_sync, 0);
    // R8 pump-only disable
    load_and_check(22'h000004, 2'd2);
    chk("R8 cnt_hold unaffected", cnt_hold, 0);
    chk("R8 cp_hiz set", cp_hiz, 1);
    // R5 func load after arming does not pulse; R/func loads never do
    load_and_check(22'h000000, 2'd3);
    load_and_check(22'h000000, 2'd2);
    load_and_check(22'h000555, 2'd0);
    load_and_check(22'h000777, 2'd1);

    for (int i = 0; i < 48; i++) begin
      logic [21:0] p;
      logic [1:0] a;
      p = 22'($urandom);
      a = 2'($urandom % 4);
      load_and_check(p, a);
    end

    // R4 pulse width
    chk("R4 pulse width", run_max, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule